// File: doc/BRIEF.md
# Dual-Clock Bidirectional Mailbox Pair

This block moves single 36-bit command words between two independently clocked ports, A and B, without passing them through the data queues. It holds two registers, one per direction. The A-to-B register is loaded from port A and read on port B. The B-to-A register is loaded from port B and read on port A. Each register has an active-low full flag in its writer's clock domain. An accepted write drives the flag low. While the flag is low, the writer's further attempts are refused. A mailbox read on the opposite port hands the register back, and the flag returns high a few writer-clock cycles later.

The set and release events cross between the clock domains as toggles through multi-flop synchronizers. The reader therefore only honours a read after the matching write has become visible in its own domain. Each port's registered read bus shows either its mailbox register or the queue output supplied by the surrounding logic, depending on that port's mailbox selection. Both resets are synchronous and active high, and must be applied together.

Top module: `mbx_bridge`

## Requirements
- R1: While reset and on the first cycles after it, both full flags (`a_mb_full_n`, `b_mb_full_n`) read 1 and both read buses read 0.
- R2: A port-A access with `a_cs`, `a_en`, `a_wr` and `a_mbox` all 1 at a rising `clk_a` edge, while `a_mb_full_n` is 1, stores `a_wdata` in the A-to-B register and drives `a_mb_full_n` to 0 after that edge.
- R3: A port-B access with `b_cs`, `b_en`, `b_wr` all 1 and `b_size` equal to 2'b11 at a rising `clk_b` edge, while `b_mb_full_n` is 1, stores `b_wdata` in the B-to-A register and drives `b_mb_full_n` to 0.
- R4: A mailbox write presented while that register's full flag is 0 is refused: the register contents and the flag do not change.
- R5: A port-B mailbox read (`b_cs`, `b_en` 1, `b_wr` 0, `b_size` 2'b11) made after the A-to-B write has crossed into `clk_b` releases the A-to-B register: `a_mb_full_n` returns to 1 within 2*SYNC_STAGES+4 `clk_a` cycles.
- R6: A port-A mailbox read (`a_cs`, `a_en` 1, `a_wr` 0, `a_mbox` 1) made after the B-to-A write has crossed into `clk_a` returns `b_mb_full_n` to 1 within the same bound in `clk_b` cycles.
- R7: A register keeps its contents after it is read and changes only on an accepted write.
- R8: `a_rdata` is registered. One `clk_a` edge after sampling, it carries the B-to-A register when `a_mbox` is 1, and `a_fifo_q` when `a_mbox` is 0.
- R9: `b_rdata` is registered. One `clk_b` edge after sampling, it carries the A-to-B register when `b_size` is 2'b11, and `b_fifo_q` for any other `b_size`.
- R10: An access with `cs` or `en` low, or without mailbox selection (`a_mbox` 0, or `b_size` not 2'b11), writes no register and moves no flag.
- R11: A mailbox read made while the register holds no uncollected word has no effect. A later write still leaves the flag low until a new read follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Synchronous active-high reset, clk_a domain |
| a_cs | input | 1 | Port A chip select, active high |
| a_en | input | 1 | Port A access enable |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_mbox | input | 1 | Port A mailbox select |
| a_wdata | input | 36 | Port A write data |
| a_fifo_q | input | 36 | Queue output shown on port A when the mailbox is not selected |
| a_rdata | output | 36 | Port A registered read bus |
| a_mb_full_n | output | 1 | A-to-B register full flag, active low, clk_a domain |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Synchronous active-high reset, clk_b domain |
| b_cs | input | 1 | Port B chip select, active high |
| b_en | input | 1 | Port B access enable |
| b_wr | input | 1 | Port B direction: 1 write, 0 read |
| b_size | input | 2 | Port B size select; 2'b11 selects the mailbox |
| b_wdata | input | 36 | Port B write data |
| b_fifo_q | input | 36 | Queue output shown on port B when the mailbox is not selected |
| b_rdata | output | 36 | Port B registered read bus |
| b_mb_full_n | output | 1 | B-to-A register full flag, active low, clk_b domain |

## Verification
The delicate overlap is a writer that keeps requesting a write to a full register while the release from the far-side read is still crossing in. The release and the next write acceptance then meet on the same writer-clock edge. The bench holds a port-A mailbox write active across a port-B read and its release. It then expects the held word to land exactly once: port B reads the new word, and the flag is low again rather than high. A second overlap has one port writing its outgoing register while reading the incoming one on alternate cycles. Both directions must keep their own data and flags.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned MBX_W = 36;
  localparam int unsigned MBX_SYNC = 2;

  typedef struct packed {
    logic wr_mbox;
    logic rd_mbox;
  } mbx_req_t;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < int'(STAGES); i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
(
  input  logic     cs,
  input  logic     en,
  input  logic     wr,
  input  logic     hit,
  output mbx_req_t req
);
  logic access;

  always_comb begin
    access      = cs & en & hit;
    req.wr_mbox = access & wr;
    req.rd_mbox = access & ~wr;
  end
endmodule

// File: rtl/mbx_rdmux.sv
module mbx_rdmux #(
  parameter int unsigned W = 36
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pick_mail,
  input  logic [W-1:0] mail,
  input  logic [W-1:0] fifo_q,
  output logic [W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= pick_mail ? mail : fifo_q;
  end
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int unsigned W     = 36,
  parameter int unsigned SYNC  = 2
) (
  input  logic         wclk,
  input  logic         wrst,
  input  logic         wr_req,
  input  logic [W-1:0] wdata,
  output logic         full_n,
  output logic [W-1:0] mail,
  input  logic         rclk,
  input  logic         rrst,
  input  logic         rd_req
);
  logic set_tog, clr_tog;
  logic set_seen, clr_seen;
  logic full_w, valid_r, accept;

  mbx_sync #(.STAGES(SYNC)) u_clr_to_w (
    .clk(wclk), .rst(wrst), .d(clr_tog), .q(clr_seen)
  );
  mbx_sync #(.STAGES(SYNC)) u_set_to_r (
    .clk(rclk), .rst(rrst), .d(set_tog), .q(set_seen)
  );

  assign full_w  = set_tog ^ clr_seen;
  assign accept  = wr_req & ~full_w;
  assign full_n  = ~full_w;
  assign valid_r = set_seen ^ clr_tog;

  always_ff @(posedge wclk) begin
    if (wrst) begin
      set_tog <= 1'b0;
      mail    <= '0;
    end else if (accept) begin
      set_tog <= ~set_tog;
      mail    <= wdata;
    end
  end

  always_ff @(posedge rclk) begin
    if (rrst)                   clr_tog <= 1'b0;
    else if (rd_req && valid_r) clr_tog <= ~clr_tog;
  end

  // R2 / R3: an accepted write leaves the flag low on the next edge
  a_r2_flag_set: assert property (@(posedge wclk) disable iff (wrst)
    (wr_req && full_n) |=> !full_n);
  // R4: a write against a full register leaves its contents alone
  a_r4_write_refused: assert property (@(posedge wclk) disable iff (wrst)
    (wr_req && !full_n) |=> $stable(mail));
  // R7: without a write request the contents never move
  a_r7_contents_hold: assert property (@(posedge wclk) disable iff (wrst)
    !wr_req |=> $stable(mail));
  // R5 / R6: one honoured read consumes the word in the reader domain
  a_r5_read_consumes: assert property (@(posedge rclk) disable iff (rrst)
    (rd_req && valid_r) |=> !valid_r);
endmodule

// File: rtl/mbx_bridge.sv
module mbx_bridge
  import mbx_pkg::*;
#(
  parameter int unsigned W           = MBX_W,
  parameter int unsigned SYNC_STAGES = MBX_SYNC
) (
  input  logic         clk_a,
  input  logic         rst_a,
  input  logic         a_cs,
  input  logic         a_en,
  input  logic         a_wr,
  input  logic         a_mbox,
  input  logic [W-1:0] a_wdata,
  input  logic [W-1:0] a_fifo_q,
  output logic [W-1:0] a_rdata,
  output logic         a_mb_full_n,
  input  logic         clk_b,
  input  logic         rst_b,
  input  logic         b_cs,
  input  logic         b_en,
  input  logic         b_wr,
  input  logic [1:0]   b_size,
  input  logic [W-1:0] b_wdata,
  input  logic [W-1:0] b_fifo_q,
  output logic [W-1:0] b_rdata,
  output logic         b_mb_full_n
);
  mbx_req_t req_a, req_b;
  logic     b_hit;
  logic [W-1:0] mail_ab, mail_ba;

  assign b_hit = &b_size;

  mbx_decode u_dec_a (.cs(a_cs), .en(a_en), .wr(a_wr), .hit(a_mbox), .req(req_a));
  mbx_decode u_dec_b (.cs(b_cs), .en(b_en), .wr(b_wr), .hit(b_hit),  .req(req_b));

  mbx_channel #(.W(W), .SYNC(SYNC_STAGES)) u_ab (
    .wclk(clk_a), .wrst(rst_a), .wr_req(req_a.wr_mbox), .wdata(a_wdata),
    .full_n(a_mb_full_n), .mail(mail_ab),
    .rclk(clk_b), .rrst(rst_b), .rd_req(req_b.rd_mbox)
  );

  mbx_channel #(.W(W), .SYNC(SYNC_STAGES)) u_ba (
    .wclk(clk_b), .wrst(rst_b), .wr_req(req_b.wr_mbox), .wdata(b_wdata),
    .full_n(b_mb_full_n), .mail(mail_ba),
    .rclk(clk_a), .rrst(rst_a), .rd_req(req_a.rd_mbox)
  );

  mbx_rdmux #(.W(W)) u_mux_a (
    .clk(clk_a), .rst(rst_a), .pick_mail(a_mbox),
    .mail(mail_ba), .fifo_q(a_fifo_q), .rdata(a_rdata)
  );
  mbx_rdmux #(.W(W)) u_mux_b (
    .clk(clk_b), .rst(rst_b), .pick_mail(b_hit),
    .mail(mail_ab), .fifo_q(b_fifo_q), .rdata(b_rdata)
  );

  // R10: an access without mailbox selection never moves port A's flag low
  a_r10_unselected_a: assert property (@(posedge clk_a) disable iff (rst_a)
    (a_mb_full_n && !(a_cs && a_en && a_wr && a_mbox)) |=> a_mb_full_n);
  a_r10_unselected_b: assert property (@(posedge clk_b) disable iff (rst_b)
    (b_mb_full_n && !(b_cs && b_en && b_wr && b_hit)) |=> b_mb_full_n);
endmodule

// File: tb/mbx_bridge_test.sv
module mbx_bridge_test;
  localparam int W = 36;
  logic clk_a = 0, clk_b = 0, rst_a = 1, rst_b = 1;
  logic a_cs = 0, a_en = 0, a_wr = 0, a_mbox = 0;
  logic b_cs = 0, b_en = 0, b_wr = 0;
  logic [1:0] b_size = 2'b00;
  logic [W-1:0] a_wdata = '0, a_fifo_q = '0, b_wdata = '0, b_fifo_q = '0;
  logic [W-1:0] a_rdata, b_rdata;
  logic a_mb_full_n, b_mb_full_n;
  int vectors = 0, errors = 0;
  bit done = 0;

  always #2.5 clk_a = ~clk_a;
  always #3.5 clk_b = ~clk_b;

  mbx_bridge uut (.*);

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_a(int n);
    for (int i = 0; i < n; i++) @(negedge clk_a);
  endtask
  task automatic idle_b(int n);
    for (int i = 0; i < n; i++) @(negedge clk_b);
  endtask

  task automatic op_a(bit cs, bit en, bit wr, bit mb, logic [W-1:0] d);
    @(negedge clk_a);
    a_cs = cs; a_en = en; a_wr = wr; a_mbox = mb; a_wdata = d;
    @(negedge clk_a);
    a_cs = 0; a_en = 0; a_wr = 0;
  endtask
  task automatic op_b(bit cs, bit en, bit wr, logic [1:0] sz, logic [W-1:0] d);
    @(negedge clk_b);
    b_cs = cs; b_en = en; b_wr = wr; b_size = sz; b_wdata = d;
    @(negedge clk_b);
    b_cs = 0; b_en = 0; b_wr = 0;
  endtask

  // Port-B view of the A-to-B register (R9 path)
  task automatic peek_b(output logic [W-1:0] v);
    @(negedge clk_b); b_size = 2'b11;
    idle_b(1); v = b_rdata;
  endtask
  task automatic peek_a(output logic [W-1:0] v);
    @(negedge clk_a); a_mbox = 1;
    idle_a(1); v = a_rdata;
  endtask

  task automatic t_reset;
    idle_a(1);
    chk("R1 a flag", {35'b0, a_mb_full_n}, 1);
    chk("R1 b flag", {35'b0, b_mb_full_n}, 1);
    chk("R1 a_rdata", a_rdata, 0);
    chk("R1 b_rdata", b_rdata, 0);
    @(negedge clk_a); rst_a = 0; rst_b = 0;
    idle_a(1);
    chk("R1 a flag after", {35'b0, a_mb_full_n}, 1);
  endtask

  task automatic t_mux;
    logic [W-1:0] v;
    a_fifo_q = 36'hA_5A5A_5A5A; b_fifo_q = 36'h3_C3C3_C3C3;
    @(negedge clk_a); a_mbox = 0; idle_a(1);
    chk("R8 fifo on A", a_rdata, 36'hA_5A5A_5A5A);
    for (int s = 0; s < 3; s++) begin
      @(negedge clk_b); b_size = s[1:0]; idle_b(1);
      chk("R9 fifo on B", b_rdata, 36'h3_C3C3_C3C3);
    end
    peek_b(v); chk("R9 mail on B", v, 0);
  endtask

  task automatic t_unqualified;
    logic [W-1:0] v;
    op_a(0, 1, 1, 1, 36'h1_1111_1111);
    op_a(1, 0, 1, 1, 36'h2_2222_2222);
    op_a(1, 1, 1, 0, 36'h3_3333_3333);
    idle_a(1);
    chk("R10 a flag", {35'b0, a_mb_full_n}, 1);
    op_b(1, 1, 1, 2'b10, 36'h4_4444_4444);
    idle_b(1);
    chk("R10 b flag", {35'b0, b_mb_full_n}, 1);
    peek_b(v); chk("R10 mail1 untouched", v, 0);
    peek_a(v); chk("R10 mail2 untouched", v, 0);
  endtask

  task automatic t_a_to_b;
    logic [W-1:0] v;
    op_a(1, 1, 1, 1, 36'hF_0123_4567);
    chk("R2 flag low", {35'b0, a_mb_full_n}, 0);
    op_a(1, 1, 1, 1, 36'h0_DEAD_BEEF);
    chk("R4 flag still low", {35'b0, a_mb_full_n}, 0);
    idle_b(4);
    peek_b(v); chk("R4 refused write", v, 36'hF_0123_4567);
    op_b(1, 1, 0, 2'b11, 0);
    idle_a(2*2+4);
    chk("R5 flag released", {35'b0, a_mb_full_n}, 1);
    peek_b(v); chk("R7 data kept", v, 36'hF_0123_4567);
  endtask

  task automatic t_b_to_a;
    logic [W-1:0] v;
    op_b(1, 1, 1, 2'b11, 36'h9_8765_4321);
    chk("R3 flag low", {35'b0, b_mb_full_n}, 0);
    idle_a(4);
    peek_a(v); chk("R8 mail2 on A", v, 36'h9_8765_4321);
    op_a(1, 1, 0, 1, 0);
    idle_b(2*2+4);
    chk("R6 flag released", {35'b0, b_mb_full_n}, 1);
    peek_a(v); chk("R7 mail2 kept", v, 36'h9_8765_4321);
  endtask

  task automatic t_stale_read;
    // R11: a read of an empty register does not pre-release a later write
    op_b(1, 1, 0, 2'b11, 0);
    idle_b(2);
    op_a(1, 1, 1, 1, 36'h5_5555_0000);
    idle_a(12);
    chk("R11 flag stays low", {35'b0, a_mb_full_n}, 0);
    op_b(1, 1, 0, 2'b11, 0);
    idle_a(8);
    chk("R11 released by fresh read", {35'b0, a_mb_full_n}, 1);
  endtask

  task automatic t_overlap;
    logic [W-1:0] v;
    op_a(1, 1, 1, 1, 36'h7_0000_0001);
    idle_b(4);
    @(negedge clk_a);
    a_cs = 1; a_en = 1; a_wr = 1; a_mbox = 1; a_wdata = 36'h7_0000_0002;
    op_b(1, 1, 0, 2'b11, 0);
    idle_a(12);
    a_cs = 0; a_en = 0; a_wr = 0;
    chk("R4 held write lands, flag low", {35'b0, a_mb_full_n}, 0);
    idle_b(4);
    peek_b(v); chk("R2 held word visible", v, 36'h7_0000_0002);
    op_b(1, 1, 0, 2'b11, 0);
    idle_a(8);
    chk("R5 released once", {35'b0, a_mb_full_n}, 1);
  endtask

  initial begin
    t_reset();
    t_mux();
    t_unqualified();
    t_a_to_b();
    t_b_to_a();
    t_stale_read();
    t_overlap();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk_a);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule